// File: doc/BRIEF.md
# Dual-Channel Output Compare Waveform Unit

The block holds two output-compare channels that watch one shared free-running up/down counter. The counter is outside the block; only its state comes in: the count value, the direction, and strobes for the peak count, the zero count and the stopped state. Each channel keeps a staged compare value and a live compare value. The live value is compared with the count, and on a match the channel updates its waveform pin and raises a sticky match flag.

One pair-wide mode field selects how the two pins react. In the plain toggle mode each pin inverts on its own match, and the two channels run independently. In the coupled two-edge mode, pin 1 inverts on a match against either compare value, while pin 0 keeps plain toggling. The two up/down modes drive a pin to its active level on a match while counting up, and to its inactive level on a match while counting down. In these modes the compare values zero and all-ones force the pin steadily active or steadily inactive. The active level is high in one up/down mode and low in the other.

Software writes land in the staged register. A shared transfer field then copies the staged value into the live register in one of three ways: at once on the write, at the zero count, or at the peak count. The buffered cases also copy whenever the counter is stopped. A copied value takes part in the comparison during the very cycle in which it is copied.

Top module: `ocu_pair`

## Requirements
- R1: While reset is held and just after it is released, rt0, rt1, iop0 and iop1 are low and live0 and live1 are zero.
- R2: With mode 2'b00, an enabled channel whose live compare value equals the count inverts its pin on the next clock edge and sets its flag, in either count direction; each channel acts only on its own compare value.
- R3: A compare value above the counter's peak never produces a match, so the pin and the flag stay unchanged through whole count cycles.
- R4: With mode 2'b01, rt1 inverts once for each cycle in which the count equals either live value, and only when both enables (ch_en[0] for channel 0, ch_en[1] for channel 1) are set; equal live values give a single inversion. Channel 0 keeps the toggle behaviour of R2.
- R5: iop0 sets on a channel-0 match and iop1 on a channel-1 match. Writing one to flag_clr[i] clears flag i. A set in the same cycle wins over the clear.
- R6: With mode 2'b10 (active high) or 2'b11 (active low), and a live value other than zero or all-ones, a match while cnt_up is 1 drives the pin to the active level. A match while cnt_up is 0 drives it to the inactive level. Cycles without a match hold the pin.
- R7: In the up/down modes, a match in a cycle where at_peak is high changes neither the pin nor the flag.
- R8: In the up/down modes, an enabled channel whose live value is zero drives its pin active every cycle; a live value of all-ones drives it inactive every cycle.
- R9: The xfer field selects the copy from staged to live. 2'b00 copies on the write itself. 2'b01 copies when at_zero or stopped is high. 2'b10 and 2'b11 copy when at_peak or stopped is high. The copied value is compared in the cycle of the copy.
- R10: A channel whose enable is low leaves its pin and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | W | Counter value |
| cnt_up | input | 1 | 1 while the counter counts up |
| at_peak | input | 1 | Counter is at its peak count |
| at_zero | input | 1 | Counter is at zero |
| stopped | input | 1 | Counter is halted |
| ch_en | input | 2 | Per-channel enable, bit i for channel i |
| mode | input | 2 | Pair mode: 00 toggle, 01 two-edge on pin 1, 10 up/down active high, 11 up/down active low |
| xfer | input | 2 | Staged-to-live copy timing |
| wr | input | 2 | Write strobe into the staged register of channel i |
| wdata | input | W | Write data |
| flag_clr | input | 2 | Write-one-to-clear for the flags |
| live0 | output | W | Live compare value, channel 0 |
| live1 | output | W | Live compare value, channel 1 |
| rt0 | output | 1 | Waveform pin, channel 0 |
| rt1 | output | 1 | Waveform pin, channel 1 |
| iop0 | output | 1 | Match flag, channel 0 |
| iop1 | output | 1 | Match flag, channel 1 |

## Verification
The bench builds the block with its default 16-bit width. At that width the all-ones value 0xFFFF is exactly the inactive-hold value of the up/down modes. A small peak of 10 lets a compare value of 20 sit above the peak, so a full count cycle shows that it never matches. Short counts also let the same run reach equal compare values in the two-edge mode and peak-timed copies that match in the copy cycle.

// File: rtl/ocu_pair.sv
module ocu_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         cnt_up,
  input  logic         at_peak,
  input  logic         at_zero,
  input  logic         stopped,
  input  logic [1:0]   ch_en,
  input  logic [1:0]   mode,
  input  logic [1:0]   xfer,
  input  logic [1:0]   wr,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   flag_clr,
  output logic [W-1:0] live0,
  output logic [W-1:0] live1,
  output logic         rt0,
  output logic         rt1,
  output logic         iop0,
  output logic         iop1
);
  localparam logic [W-1:0] ALL1 = '1;

  logic [1:0][W-1:0] stage_q, live_q, eff;
  logic [1:0]        hit, rt_q, rt_d, iop_q, setf;

  wire ud      = mode[1];
  wire act_lvl = ~mode[0];
  wire two_chg = (mode == 2'b01);
  wire direct  = (xfer == 2'b00);
  wire load    = xfer[1] ? (at_peak | stopped) : (at_zero | stopped);

  function automatic logic next_lvl(logic cur, logic en, logic [W-1:0] c,
                                    logic h);
    if (!en) return cur;
    if (ud) begin
      if (c == '0)   return act_lvl;
      if (c == ALL1) return ~act_lvl;
      if (h && !at_peak) return cnt_up ? act_lvl : ~act_lvl;
      return cur;
    end
    return h ? ~cur : cur;
  endfunction

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      if (direct)
        eff[i] = wr[i] ? wdata : live_q[i];
      else
        eff[i] = load ? stage_q[i] : live_q[i];
      hit[i]  = ch_en[i] && (cnt == eff[i]);
      setf[i] = hit[i] && !(ud && at_peak);
    end
    rt_d[0] = next_lvl(rt_q[0], ch_en[0], eff[0], hit[0]);
    if (two_chg)
      rt_d[1] = (ch_en[0] && ch_en[1] && (cnt == eff[0] || cnt == eff[1]))
                ? ~rt_q[1] : rt_q[1];
    else
      rt_d[1] = next_lvl(rt_q[1], ch_en[1], eff[1], hit[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
      rt_q    <= '0;
      iop_q   <= '0;
    end else begin
      for (int i = 0; i < 2; i++)
        if (wr[i]) stage_q[i] <= wdata;
      live_q <= eff;
      rt_q   <= rt_d;
      iop_q  <= (iop_q & ~flag_clr) | setf;
    end
  end

  assign live0 = live_q[0];
  assign live1 = live_q[1];
  assign rt0   = rt_q[0];
  assign rt1   = rt_q[1];
  assign iop0  = iop_q[0];
  assign iop1  = iop_q[1];
endmodule

// File: rtl/ocu_pair_chk.sv
module ocu_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic         cnt_up,
  input logic         at_peak,
  input logic         at_zero,
  input logic         stopped,
  input logic [1:0]   ch_en,
  input logic [1:0]   mode,
  input logic [1:0]   xfer,
  input logic [1:0]   wr,
  input logic [W-1:0] wdata,
  input logic [1:0]   flag_clr,
  input logic [W-1:0] live0,
  input logic [W-1:0] live1,
  input logic         rt0,
  input logic         rt1,
  input logic         iop0,
  input logic         iop1
);
  localparam logic [W-1:0] ALL1 = '1;

  wire quiet0 = (xfer == 2'b00) && !wr[0];
  wire quiet1 = (xfer == 2'b00) && !wr[1];

  // R1
  reset_low_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rt0 && !rt1 && !iop0 && !iop1 && live0 == '0 && live1 == '0));

  // R2
  toggle_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && ch_en[0] && quiet0 && cnt == live0) |=> (rt0 != $past(rt0)));

  // R4
  two_edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && ch_en == 2'b11 && quiet0 && quiet1 && cnt == live0 && cnt == live1)
      |=> (rt1 != $past(rt1)));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en[0] && quiet0 && cnt == live0 && !(mode[1] && at_peak)) |=> iop0);

  // R6
  ud_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && ch_en[0] && quiet0 && cnt == live0 && live0 != '0 && live0 != ALL1
     && !at_peak && cnt_up) |=> (rt0 == !$past(mode[0])));

  // R7
  peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && quiet0 && at_peak && live0 != '0 && live0 != ALL1 && !flag_clr[0])
      |=> ($stable(rt0) && $stable(iop0)));

  // R8
  zero_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && ch_en[0] && quiet0 && live0 == '0) |=> (rt0 == !$past(mode[0])));

  // R10
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en[0] && !flag_clr[0]) |=> ($stable(rt0) && $stable(iop0)));

  // R10
  disabled_hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en[1] && !flag_clr[1]) |=> ($stable(rt1) && $stable(iop1)));
endmodule

bind ocu_pair ocu_pair_chk #(.W(W)) u_chk (.*);

// File: tb/sim_ocu_pair.sv
`timescale 1ns/1ps
module sim_ocu_pair;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cnt = 16'd1000, wdata = '0;
  logic        cnt_up = 1, at_peak = 0, at_zero = 0, stopped = 0;
  logic [1:0]  ch_en = 2'b11, mode = 2'b00, xfer = 2'b00, wr = 2'b00, flag_clr = 2'b00;
  logic [15:0] live0, live1;
  logic        rt0, rt1, iop0, iop1;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ocu_pair #(.W(16)) u0 (.*);

  typedef struct packed {
    logic [15:0] c; logic up; logic [1:0] en; logic [1:0] clr;
    logic [1:0] rt; logic [1:0] iop;
  } vec_t;

  localparam vec_t TBL[8] = '{
    '{16'd0, 1'b1, 2'b11, 2'b00, 2'b00, 2'b00},
    '{16'd3, 1'b1, 2'b11, 2'b00, 2'b01, 2'b01},
    '{16'd5, 1'b1, 2'b11, 2'b00, 2'b11, 2'b11},
    '{16'd6, 1'b1, 2'b11, 2'b11, 2'b11, 2'b00},
    '{16'd5, 1'b0, 2'b11, 2'b00, 2'b01, 2'b10},
    '{16'd3, 1'b0, 2'b01, 2'b00, 2'b00, 2'b11},
    '{16'd5, 1'b0, 2'b01, 2'b00, 2'b00, 2'b11},
    '{16'd3, 1'b1, 2'b11, 2'b01, 2'b01, 2'b11}
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; cnt = 16'd1000; wr = 0; flag_clr = 0; at_peak = 0; at_zero = 0;
    stopped = 0; cnt_up = 1;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic wr_ch(int ch, logic [15:0] v);
    wdata = v; wr = (ch == 0) ? 2'b01 : 2'b10;
    tick();
    wr = 2'b00;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick();
    do_reset();
    // R1 reset state
    chk("R1 rt", {rt1, rt0}, 0);
    chk("R1 iop", {iop1, iop0}, 0);
    chk("R1 live", live0 | live1, 0);

    // R2 R5 R10 table walk, toggle mode, direct copy
    mode = 2'b00; xfer = 2'b00; ch_en = 2'b11;
    wr_ch(0, 16'd3); wr_ch(1, 16'd5);
    foreach (TBL[i]) begin
      cnt = TBL[i].c; cnt_up = TBL[i].up; ch_en = TBL[i].en; flag_clr = TBL[i].clr;
      tick();
      chk($sformatf("R2 R10 row%0d rt", i), {rt1, rt0}, TBL[i].rt);
      chk($sformatf("R5 row%0d iop", i), {iop1, iop0}, TBL[i].iop);
    end
    flag_clr = 0; ch_en = 2'b11;

    // R3 value above peak
    do_reset(); ch_en = 2'b01;
    wr_ch(0, 16'd20);
    for (int k = 0; k <= 21; k++) begin
      cnt = (k <= 10) ? k[15:0] : 16'(k - 11);
      at_peak = (cnt == 16'd10); at_zero = (cnt == 0);
      tick();
    end
    at_peak = 0; at_zero = 0;
    chk("R3 rt0", rt0, 0);
    chk("R3 iop0", iop0, 0);

    // R4 two-edge mode
    do_reset(); mode = 2'b01; ch_en = 2'b11;
    wr_ch(0, 16'd4); wr_ch(1, 16'd8);
    cnt = 4; tick();
    chk("R4 c0 rt", {rt1, rt0}, 2'b11);
    chk("R4 c0 iop", {iop1, iop0}, 2'b01);
    cnt = 8; tick();
    chk("R4 c1 rt", {rt1, rt0}, 2'b01);
    chk("R4 c1 iop", {iop1, iop0}, 2'b11);
    cnt = 1000; wr_ch(1, 16'd4);
    cnt = 4; tick();
    chk("R4 equal single", {rt1, rt0}, 2'b10);
    ch_en = 2'b10; tick();
    chk("R4 needs both enables", {rt1, rt0}, 2'b10);
    ch_en = 2'b11;

    // R6 up/down polarity
    do_reset(); mode = 2'b10; ch_en = 2'b01;
    wr_ch(0, 16'd6);
    cnt = 6; cnt_up = 1; tick();
    chk("R6 hi up", rt0, 1);
    cnt = 7; tick();
    chk("R6 hi hold", rt0, 1);
    cnt = 6; cnt_up = 0; tick();
    chk("R6 hi down", rt0, 0);
    do_reset(); mode = 2'b11; ch_en = 2'b01;
    wr_ch(0, 16'd6);
    cnt = 6; cnt_up = 0; tick();
    chk("R6 lo down", rt0, 1);
    cnt = 6; cnt_up = 1; tick();
    chk("R6 lo up", rt0, 0);

    // R7 peak match ignored
    do_reset(); mode = 2'b10; ch_en = 2'b01;
    wr_ch(0, 16'd9);
    cnt = 9; at_peak = 1; cnt_up = 1; tick();
    at_peak = 0;
    chk("R7 rt0", rt0, 0);
    chk("R7 iop0", iop0, 0);

    // R8 zero and all-ones
    do_reset(); mode = 2'b10; ch_en = 2'b01; cnt = 5;
    tick();
    chk("R8 zero active", rt0, 1);
    wr_ch(0, 16'hFFFF);
    chk("R8 ones inactive", rt0, 0);

    // R9 copy timing
    do_reset(); mode = 2'b00; ch_en = 2'b01; xfer = 2'b01;
    cnt = 3; wr_ch(0, 16'd7);
    chk("R9 zero no early copy", live0, 0);
    cnt = 7; tick();
    chk("R9 stale compare", rt0, 0);
    cnt = 0; at_zero = 1; tick(); at_zero = 0;
    chk("R9 zero copy", live0, 7);
    cnt = 7; tick();
    chk("R9 copied compare", rt0, 1);
    xfer = 2'b10; cnt = 2; wr_ch(0, 16'd10);
    chk("R9 peak no early copy", live0, 7);
    cnt = 10; at_peak = 1; tick(); at_peak = 0;
    chk("R9 peak copy", live0, 10);
    chk("R9 compared in copy cycle", rt0, 0);
    cnt = 3; wr_ch(0, 16'd12);
    stopped = 1; tick(); stopped = 0;
    chk("R9 stopped copy", live0, 12);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule